// File: doc/BRIEF.md
# Coprocessor Indirect Register Access Port

This block connects a host processor to the internal configuration registers of a decoding coprocessor. The host sees only three registers, chosen by a two-bit select: a pointer register, a data window and a command register. A read or write through the data window reaches the internal register named by the pointer. After every access through the window, the pointer advances by one, so a block of consecutive internal registers can be loaded or dumped with one pointer write and a run of data accesses.

Internal index 0 holds a 12-bit configuration word and index 1 holds an 8-bit traceback length. Every other index is unmapped. The configuration fields are decoded onto dedicated outputs that drive the decoding engine.

Writing an opcode into the command register starts an engine operation. The block then gives the engine a one-cycle start pulse with the opcode, and marks itself busy until the engine reports completion. A reset opcode returns the whole block to its idle state. Reading the command register returns the busy flag and a sticky rejection flag.

Top module: `coproc_regport`

## Requirements
- R1: After a synchronous active-low reset, the pointer, the configuration word and the traceback length are zero. `busy`, `err_flag` and `cmd_start` are low.
- R2: With `host_sel`=0, a write loads the pointer from the low bits of `host_wdata`. A read returns the pointer, zero-extended, on `host_rdata` in the same cycle.
- R3: With `host_sel`=1, a read returns the internal register at the pointer, zero-extended, in the same cycle. A write updates that register. Index 0 keeps `host_wdata[11:0]` and index 1 keeps `host_wdata[7:0]`.
- R4: Every read or write with `host_sel`=1 advances the pointer by one at the clock edge that ends the access.
- R5: Indices 2 and above read as zero and ignore writes. Accesses to them still advance the pointer.
- R6: The pointer wraps from its maximum value (15) to zero.
- R7: A write with `host_sel`=2 whose `host_wdata[2:0]` is 1 (equalize), 2 (decode) or 3 (traceback) starts an operation when the block is idle. In the next cycle `cmd_start` is high for exactly one cycle with `cmd_op` equal to the opcode. `busy` rises in that same cycle and stays high until `engine_done` is sampled high.
- R8: A start opcode written while `busy` is high produces no pulse and leaves `busy` unchanged. It sets `err_flag`, which stays set until reset. A read with `host_sel`=2 returns `busy` in bit 0 and `err_flag` in bit 1.
- R9: Opcode 7 is a reset command and is accepted even while busy. At the next edge it clears the pointer, both internal registers, `busy` and `err_flag`, and it pulses `cmd_start` with `cmd_op`=7.
- R10: Opcodes 0, 4, 5 and 6 produce no pulse and change no state.
- R11: The configuration word drives these outputs: bits [2:0] on `cfg_taps`, bits [5:3] on `cfg_klen`, bits [8:6] on `cfg_rate`, bits [10:9] on `cfg_outmode` and bit 11 on `cfg_bmsel`. The traceback length drives `cfg_tblen`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 2 | Host register select: 0 pointer, 1 data window, 2 command/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| engine_done | input | 1 | Engine finished its current operation |
| cmd_start | output | 1 | One-cycle operation start pulse |
| cmd_op | output | 3 | Opcode that goes with `cmd_start` |
| busy | output | 1 | An operation is in progress |
| err_flag | output | 1 | Sticky flag: a start was rejected while busy |
| cfg_taps | output | 3 | Equalizer tap count field |
| cfg_klen | output | 3 | Constraint length field |
| cfg_rate | output | 3 | Code rate denominator field |
| cfg_outmode | output | 2 | Output mode field (two soft variants or hard) |
| cfg_bmsel | output | 1 | Branch-metric select bit |
| cfg_tblen | output | 8 | Traceback length |

## Verification
The hardest situation to reach is a command that arrives while the block is busy. Both the rejected start opcode and the reset opcode have to land in that state. The bench first starts an operation and holds `engine_done` low, then issues a second start opcode and checks that no pulse appears and that the sticky flag stays set after completion. It then starts another operation and sends the reset opcode while busy. Reaching the pointer wrap takes a pointer write of 15 followed by a data read, and the bench checks the result through a pointer read.

// File: rtl/regport_pkg.sv
// Package: shared encodings for the indirect register access port.
// Assumes host select and opcode widths fixed by the host-visible map.
package regport_pkg;

    localparam int CTRL_W    = 12;
    localparam int REG_CTRL  = 0;
    localparam int REG_TBLEN = 1;

    typedef enum logic [1:0] {
        SEL_PTR   = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_EQU    = 3'd1,
        OP_DECODE = 3'd2,
        OP_TRACE  = 3'd3,
        OP_RESET  = 3'd7
    } opcode_e;

    typedef struct packed {
        logic       bmsel;
        logic [1:0] outmode;
        logic [2:0] rate;
        logic [2:0] klen;
        logic [2:0] taps;
    } ctrl_word_t;

    // True for opcodes that launch an engine operation.
    function automatic logic is_launch(input logic [2:0] op);
        return (op == OP_EQU) || (op == OP_DECODE) || (op == OP_TRACE);
    endfunction

endpackage

// File: rtl/rp_addr_ptr.sv
// Module: rp_addr_ptr
// Holds the index used by data-window accesses. A host load sets the index,
// each data access advances it by one with natural wrap, and clr zeroes it.
// Assumes load and step never arrive in the same cycle (distinct selects).
module rp_addr_ptr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] PTR_MAX = '1;

    // Pointer register: reset/clear, host load, or post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R4: a data access advances the pointer by one
    a_r4_post_step : assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !clr) |=> (ptr == $past(ptr) + 1'b1));

    // R6: stepping from the top index lands on zero
    a_r6_wrap_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !clr && ptr == PTR_MAX) |=> (ptr == '0));

endmodule

// File: rtl/rp_reg_file.sv
// Module: rp_reg_file
// Internal register file behind the data window: index 0 is the
// configuration word, index 1 the traceback length; other indices are
// unmapped, read zero and drop writes. Read data is combinational.
module rp_reg_file #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int TB_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [regport_pkg::CTRL_W-1:0] ctrl,
    output logic [TB_W-1:0]            tblen
);
    import regport_pkg::*;

    localparam logic [ADDR_W-1:0] IDX_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] IDX_TBLEN = ADDR_W'(REG_TBLEN);

    logic hit_ctrl;
    logic hit_tblen;

    // Index decode for the two mapped registers.
    always_comb begin
        hit_ctrl  = (addr == IDX_CTRL);
        hit_tblen = (addr == IDX_TBLEN);
    end

    // Configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctrl <= '0;
        end else if (wr && hit_ctrl) begin
            ctrl <= wdata[CTRL_W-1:0];
        end
    end

    // Traceback length storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tblen <= '0;
        end else if (wr && hit_tblen) begin
            tblen <= wdata[TB_W-1:0];
        end
    end

    // Read mux; unmapped indices return zero.
    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CTRL_W-1:0] = ctrl;
        end else if (hit_tblen) begin
            rdata[TB_W-1:0] = tblen;
        end
    end

    // R5: writes to unmapped indices leave both registers untouched
    a_r5_unmapped_write : assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && !hit_ctrl && !hit_tblen) |=> ($stable(ctrl) && $stable(tblen)));

endmodule

// File: rtl/rp_cmd_unit.sv
// Module: rp_cmd_unit
// Decodes command-register writes. Launch opcodes pulse the engine start
// when idle, or set a sticky error when busy; the reset opcode clears the
// block (clr_all is combinational so siblings clear on the same edge).
// Assumes engine_done is a single-cycle pulse from the engine.
module rp_cmd_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] opcode,
    input  logic       done,
    output logic       clr_all,
    output logic       start,
    output logic [2:0] op,
    output logic       busy,
    output logic       err
);
    import regport_pkg::*;

    logic launch_req;
    logic accept;

    // Request classification for the current command write.
    always_comb begin
        clr_all    = wr && (opcode == OP_RESET);
        launch_req = wr && is_launch(opcode);
        accept     = launch_req && !busy;
    end

    // Start pulse and opcode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            op    <= OP_IDLE;
        end else if (clr_all) begin
            start <= 1'b1;
            op    <= OP_RESET;
        end else begin
            start <= accept;
            if (accept) begin
                op <= opcode;
            end
        end
    end

    // Busy tracking: set on accepted launch, cleared by engine completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (done) begin
            busy <= 1'b0;
        end
    end

    // Sticky rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            err <= 1'b0;
        end else if (launch_req && busy) begin
            err <= 1'b1;
        end
    end

    // R7: a launch pulse always comes with busy asserted
    a_r7_busy_with_start : assert property (@(posedge clk) disable iff (!rst_n)
        (start && op != OP_RESET) |-> busy);

    // R8: a launch while busy yields no pulse and a raised error
    a_r8_reject_busy : assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && busy && !clr_all) |=> (!start && err));

    // R9: the reset pulse leaves the block idle and error-free
    a_r9_reset_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_RESET) |-> (!busy && !err));

    // R10: unknown opcodes never launch
    a_r10_unknown_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !is_launch(opcode) && opcode != OP_RESET) |=> !start);

endmodule

// File: rtl/coproc_regport.sv
// Module: coproc_regport
// Top of the indirect register access port: a pointer register, a data
// window and a command register seen by the host, in front of an internal
// register file and a command decoder for the decoding engine.
// Assumes at most one host access per cycle; host_rdata is combinational.
module coproc_regport #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int TB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              engine_done,
    output logic              cmd_start,
    output logic [2:0]        cmd_op,
    output logic              busy,
    output logic              err_flag,
    output logic [2:0]        cfg_taps,
    output logic [2:0]        cfg_klen,
    output logic [2:0]        cfg_rate,
    output logic [1:0]        cfg_outmode,
    output logic              cfg_bmsel,
    output logic [TB_W-1:0]   cfg_tblen
);
    import regport_pkg::*;

    logic              sel_ptr, sel_data, sel_cmd;
    logic              ptr_load, data_step, data_wr, cmd_wr;
    logic              clr_all;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] rf_rdata;
    logic [CTRL_W-1:0] ctrl_bits;
    ctrl_word_t        ctrl_f;

    // Host select decode and access qualification.
    always_comb begin
        sel_ptr   = (host_sel == SEL_PTR);
        sel_data  = (host_sel == SEL_DATA);
        sel_cmd   = (host_sel == SEL_CMD);
        ptr_load  = sel_ptr && host_wr;
        data_wr   = sel_data && host_wr;
        data_step = sel_data && (host_wr || host_rd);
        cmd_wr    = sel_cmd && host_wr;
    end

    rp_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .load     (ptr_load),
        .load_val (host_wdata[ADDR_W-1:0]),
        .step     (data_step),
        .ptr      (ptr)
    );

    rp_reg_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TB_W(TB_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .addr  (ptr),
        .wr    (data_wr),
        .wdata (host_wdata),
        .rdata (rf_rdata),
        .ctrl  (ctrl_bits),
        .tblen (cfg_tblen)
    );

    rp_cmd_unit u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmd_wr),
        .opcode  (host_wdata[2:0]),
        .done    (engine_done),
        .clr_all (clr_all),
        .start   (cmd_start),
        .op      (cmd_op),
        .busy    (busy),
        .err     (err_flag)
    );

    // Configuration field breakout.
    always_comb begin
        ctrl_f      = ctrl_word_t'(ctrl_bits);
        cfg_taps    = ctrl_f.taps;
        cfg_klen    = ctrl_f.klen;
        cfg_rate    = ctrl_f.rate;
        cfg_outmode = ctrl_f.outmode;
        cfg_bmsel   = ctrl_f.bmsel;
    end

    // Host read mux across the three visible registers.
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_PTR:  host_rdata[ADDR_W-1:0] = ptr;
            SEL_DATA: host_rdata = rf_rdata;
            SEL_CMD:  host_rdata[1:0] = {err_flag, busy};
            default:  host_rdata = '0;
        endcase
    end

    // R9: the reset pulse coincides with cleared configuration and pointer
    a_r9_reset_clears : assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_op == OP_RESET) |-> (ctrl_bits == '0 && cfg_tblen == '0 && ptr == '0));

    // R3: a window write to index 0 is visible in the configuration word next cycle
    a_r3_ctrl_write : assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ptr == '0) |=> (ctrl_bits == $past(host_wdata[CTRL_W-1:0])));

endmodule

// File: tb/coproc_regport_test.sv
`timescale 1ns/1ps
module coproc_regport_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd3;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        engine_done = 1'b0;
    logic        cmd_start;
    logic [2:0]  cmd_op;
    logic        busy, err_flag;
    logic [2:0]  cfg_taps, cfg_klen, cfg_rate;
    logic [1:0]  cfg_outmode;
    logic        cfg_bmsel;
    logic [7:0]  cfg_tblen;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    coproc_regport uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .engine_done(engine_done), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .busy(busy), .err_flag(err_flag), .cfg_taps(cfg_taps), .cfg_klen(cfg_klen),
        .cfg_rate(cfg_rate), .cfg_outmode(cfg_outmode), .cfg_bmsel(cfg_bmsel),
        .cfg_tblen(cfg_tblen)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        wr;
        logic        rd;
        logic [15:0] wdata;
        logic        chk;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // R2 pointer = 0
        '{2'd1, 1'b1, 1'b0, 16'hFABC, 1'b0, 16'h0000, 4'd3},  // R3 ctrl <= ABC
        '{2'd1, 1'b1, 1'b0, 16'h12F5, 1'b0, 16'h0000, 4'd3},  // R3 tblen <= F5
        '{2'd1, 1'b1, 1'b0, 16'hBEEF, 1'b0, 16'h0000, 4'd5},  // R5 unmapped write
        '{2'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0003, 4'd4},  // R4 three writes -> 3
        '{2'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{2'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0ABC, 4'd3},  // R3 ctrl masked
        '{2'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h00F5, 4'd3},  // R3 tblen masked
        '{2'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 4'd5},  // R5 unmapped reads 0
        '{2'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0003, 4'd4},  // R4 reads advance
        '{2'd0, 1'b1, 1'b0, 16'h000F, 1'b0, 16'h0000, 4'd2},
        '{2'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 4'd6},  // R6 index 15 reads 0
        '{2'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 4'd6},  // R6 wrapped to 0
        '{2'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0ABC, 4'd3},
        '{2'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0001, 4'd2}   // R2 pointer read
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host cycle: drive at negedge, sample read data, pass the edge.
    task automatic access(input logic [1:0] sel, input logic wr, input logic rd,
                          input logic [15:0] wd, output logic [15:0] rdv);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        #1 rdv = host_rdata;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0; host_sel = 2'd3;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 cmd_start", {15'd0, cmd_start}, 16'd0);
        check("R1 busy/err", {14'd0, err_flag, busy}, 16'd0);
        check("R1 cfg_tblen", {8'd0, cfg_tblen}, 16'd0);
        access(2'd0, 1'b0, 1'b1, 16'd0, rv);
        check("R1 pointer", rv, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].sel, VEC[i].wr, VEC[i].rd, VEC[i].wdata, rv);
            if (VEC[i].chk) begin
                checks++;
                if (rv !== VEC[i].exp) begin
                    errors++;
                    $display("FAIL vector %0d R%0d actual=%h expected=%h",
                             i, VEC[i].req, rv, VEC[i].exp);
                end
            end
        end

        // R11 field breakout of ctrl = 0xABC
        check("R11 fields", {3'd0, cfg_bmsel, cfg_outmode, cfg_rate, cfg_klen, cfg_taps},
              16'h0ABC);
        check("R11 taps", {13'd0, cfg_taps}, 16'd4);
        check("R11 tblen", {8'd0, cfg_tblen}, 16'h00F5);

        // R7 launch decode
        access(2'd2, 1'b1, 1'b0, 16'd2, rv);
        check("R7 start pulse", {12'd0, cmd_start, cmd_op}, {12'd0, 1'b1, 3'd2});
        check("R7 busy set", {15'd0, busy}, 16'd1);
        idle_cycle();
        check("R7 pulse one cycle", {15'd0, cmd_start}, 16'd0);
        check("R7 busy held", {15'd0, busy}, 16'd1);

        // R8 launch while busy
        access(2'd2, 1'b1, 1'b0, 16'd1, rv);
        check("R8 no pulse", {15'd0, cmd_start}, 16'd0);
        check("R8 err set", {15'd0, err_flag}, 16'd1);
        access(2'd2, 1'b0, 1'b1, 16'd0, rv);
        check("R8 status busy+err", rv, 16'h0003);
        @(negedge clk) engine_done = 1'b1;
        @(posedge clk) #1 engine_done = 1'b0;
        check("R7 done clears busy", {15'd0, busy}, 16'd0);
        access(2'd2, 1'b0, 1'b1, 16'd0, rv);
        check("R8 err sticky", rv, 16'h0002);

        // R10 unknown opcode
        access(2'd2, 1'b1, 1'b0, 16'd5, rv);
        check("R10 no pulse", {15'd0, cmd_start}, 16'd0);
        check("R10 still idle", {14'd0, err_flag, busy}, 16'h0002);

        // R9 reset opcode while busy
        access(2'd2, 1'b1, 1'b0, 16'd3, rv);
        check("R7 trace start", {12'd0, cmd_start, cmd_op}, {12'd0, 1'b1, 3'd3});
        access(2'd2, 1'b1, 1'b0, 16'd7, rv);
        check("R9 reset pulse", {12'd0, cmd_start, cmd_op}, {12'd0, 1'b1, 3'd7});
        check("R9 busy/err clear", {14'd0, err_flag, busy}, 16'd0);
        check("R9 tblen clear", {8'd0, cfg_tblen}, 16'd0);
        access(2'd0, 1'b0, 1'b1, 16'd0, rv);
        check("R9 pointer clear", rv, 16'd0);
        access(2'd1, 1'b0, 1'b1, 16'd0, rv);
        check("R9 ctrl clear", rv, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule